// File: doc/BRIEF.md
# Chip Time-of-Day Synchronisation Controller

This block is the per-chip controller that brings a chip's time-of-day facility from its power-on error state into a running, synchronised condition, and then hands the time value to one core's timebase. Software drives it through a 64-bit register port addressed by word offset. Register bits are numbered big-endian, so bit 0 is the most significant bit of the data word. A four-state machine (error, not set, stopped, running) advances on load, modify, start and invalidate commands, and on synchronisation triggers that arrive from peer chips.

Writes to the two trigger offsets send a trigger outward for the other chips. The block never applies its own outbound trigger to itself. Triggers from peers come in on a valid/ready channel. A separate register latches which core receives the time transfer, named by either a full register address or a core number. A transfer command produces a one-cycle pulse for the latched core if that core reports ready. A command that is rejected leaves the state unchanged, records a cause bit in a write-one-to-clear error register, and raises a sticky flag.

Top module: `tod_sync_ctrl`

## Requirements
- R1: After reset the state is error (code 0), the error register reads 0, the illegal flag is low, no trigger is pending and no transfer pulse is present. State codes are error=0, stopped=1, running=2, not set=7.
- R2: A write to offset 0x18 with bit 0 set moves any state to not set. With bit 0 clear the write is rejected and error bit 0 is set.
- R3: A write to offset 0x21 is accepted only in not set: data bit 63 = 1 leads to stopped and bit 63 = 0 leads to running. In any other state the write is rejected and error bit 1 is set.
- R4: A write to offset 0x22 moves stopped to running. In any other state it is rejected and error bit 2 is set.
- R5: An accepted incoming trigger of type 1 (invalidate) forces not set from any state. An accepted trigger of type 0 (send) moves not set to running; in any other state it is rejected and error bit 3 is set. trig_in_ready is low during any register write cycle.
- R6: A write to offset 0x15 (send, type 0) or 0x16 (invalidate, type 1) presents that type on trig_out until it is accepted and does not change the local state. A trigger write while an earlier one is still unaccepted is rejected and error bit 9 is set.
- R7: Offset 0x08 always reads bits 6 to 10, 12, 21 and 26 set, and bit 20 while running. Exactly one role bit is set: 23 when primary, else 24 when secondary, else 25.
- R8: Offset 0x07 keeps only bits 0 to 31. Bit 1 is forced to the primary strap and bit 2 to 1, both on every write and at reset.
- R9: Offset 0x30 is write-one-to-clear. illegal_cmd is high whenever any error bit is set. Offset 0x24 reads bit 4 set while running and 0 otherwise.
- R10: A write to offset 0x27 latches the transfer target. If bit 35 is set, data bits 0 to 31 form an address whose low 12 bits must be 0x4A3, with the core number in address bits 28:24 (little-endian) and the rest equal to 0x20000000. Otherwise the core number is data bits 26 to 31 masked to 5 bits. A core number of NUM_CORES or more, or a bad address, invalidates the target and sets error bit 8.
- R11: A write to offset 0x17 with bit 0 set produces xfer_pulse for exactly one cycle, with xfer_core naming the target, when the state is running, a valid target is latched and that core's ready bit is high. Otherwise no pulse is produced and error bit 4 (not running), 5 (bit 0 clear), 6 (no target) or 7 (core not ready) is set, checked in that order.
- R12: A read returns data on rsp_valid in the following cycle. Undecoded offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_primary | input | 1 | Strap: chip is primary master |
| is_secondary | input | 1 | Strap: chip is backup master |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Word offset |
| acc_wdata | input | 64 | Write data, big-endian bit numbering |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_data | output | 64 | Read data |
| trig_in_valid | input | 1 | Trigger from a peer chip |
| trig_in_ready | output | 1 | Trigger can be accepted this cycle |
| trig_in_type | input | 1 | 0 = send, 1 = invalidate |
| trig_out_valid | output | 1 | Outbound trigger pending |
| trig_out_ready | input | 1 | Peer fabric takes the trigger |
| trig_out_type | output | 1 | 0 = send, 1 = invalidate |
| core_ready | input | NUM_CORES | Per-core ready to take the time value |
| xfer_pulse | output | 1 | One-cycle transfer pulse |
| xfer_core | output | $clog2(NUM_CORES) | Core that receives the transfer |
| illegal_cmd | output | 1 | Sticky rejected-command flag |
| fsm_state | output | 3 | Current state code |

## Verification
A write, an accepted incoming trigger, a pending outbound trigger and a read response all become visible one clock edge after the cycle that carries them. fsm_state, illegal_cmd, trig_out_valid, xfer_pulse and rsp_data therefore change at the edge that closes the access. The bench drives every access at a falling edge and samples at the next falling edge. For transfer pulses it samples one more falling edge later to confirm the pulse has ended. trig_in_ready is the only combinational result, and it is sampled before the edge of the cycle it qualifies.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef enum logic [2:0] {
    ST_ERROR   = 3'd0,
    ST_STOPPED = 3'd1,
    ST_RUNNING = 3'd2,
    ST_NOT_SET = 3'd7
  } tod_state_e;

  localparam int DW = 64;

  // word offsets decoded by the block
  localparam logic [7:0] OFF_CTRL   = 8'h07;
  localparam logic [7:0] OFF_STATUS = 8'h08;
  localparam logic [7:0] OFF_SEND   = 8'h15;
  localparam logic [7:0] OFF_INVAL  = 8'h16;
  localparam logic [7:0] OFF_MOVE   = 8'h17;
  localparam logic [7:0] OFF_LDMOD  = 8'h18;
  localparam logic [7:0] OFF_LOAD   = 8'h21;
  localparam logic [7:0] OFF_START  = 8'h22;
  localparam logic [7:0] OFF_FSM    = 8'h24;
  localparam logic [7:0] OFF_TARGET = 8'h27;
  localparam logic [7:0] OFF_ERR    = 8'h30;

  // rejection causes, value = big-endian bit of the error register
  localparam int C_LDMOD_DATA = 0;
  localparam int C_LOAD_STATE = 1;
  localparam int C_START_STATE = 2;
  localparam int C_SEND_STATE = 3;
  localparam int C_MV_STATE   = 4;
  localparam int C_MV_DATA    = 5;
  localparam int C_MV_NOTGT   = 6;
  localparam int C_MV_NOTRDY  = 7;
  localparam int C_TGT_BAD    = 8;
  localparam int C_BC_BUSY    = 9;
  localparam int NCAUSE       = 10;

  // big-endian bit number to little-endian vector index
  function automatic int be(input int b);
    return DW - 1 - b;
  endfunction

  typedef struct packed {
    logic ctrl;
    logic send;
    logic inval;
    logic move;
    logic ldmod;
    logic load;
    logic start;
    logic target;
    logic err;
  } cmd_t;

endpackage

// File: rtl/tod_cmd_dec.sv
module tod_cmd_dec
  import tod_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  output cmd_t          cmd,
  output logic          rd_en
);
  logic wr;
  assign wr    = acc_valid && acc_write;
  assign rd_en = acc_valid && !acc_write;

  always_comb begin
    cmd        = '0;
    cmd.ctrl   = wr && (acc_addr == AW'(OFF_CTRL));
    cmd.send   = wr && (acc_addr == AW'(OFF_SEND));
    cmd.inval  = wr && (acc_addr == AW'(OFF_INVAL));
    cmd.move   = wr && (acc_addr == AW'(OFF_MOVE));
    cmd.ldmod  = wr && (acc_addr == AW'(OFF_LDMOD));
    cmd.load   = wr && (acc_addr == AW'(OFF_LOAD));
    cmd.start  = wr && (acc_addr == AW'(OFF_START));
    cmd.target = wr && (acc_addr == AW'(OFF_TARGET));
    cmd.err    = wr && (acc_addr == AW'(OFF_ERR));
  end
endmodule

// File: rtl/tod_fsm.sv
module tod_fsm
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_ldmod,
  input  logic              do_load,
  input  logic              do_start,
  input  logic              do_move,
  input  logic              bit0,
  input  logic              bit63,
  input  logic              trig_fire,
  input  logic              trig_inval,
  input  logic              tgt_valid,
  input  logic              tgt_ready,
  output tod_state_e        state,
  output logic              move_fire,
  output logic [NCAUSE-1:0] cause
);
  tod_state_e nxt;

  always_comb begin
    nxt       = state;
    cause     = '0;
    move_fire = 1'b0;
    if (do_ldmod) begin
      if (bit0) nxt = ST_NOT_SET;
      else      cause[C_LDMOD_DATA] = 1'b1;
    end
    if (do_load) begin
      if (state == ST_NOT_SET) nxt = bit63 ? ST_STOPPED : ST_RUNNING;
      else                     cause[C_LOAD_STATE] = 1'b1;
    end
    if (do_start) begin
      if (state == ST_STOPPED) nxt = ST_RUNNING;
      else                     cause[C_START_STATE] = 1'b1;
    end
    if (do_move) begin
      if (state != ST_RUNNING) cause[C_MV_STATE]  = 1'b1;
      else if (!bit0)          cause[C_MV_DATA]   = 1'b1;
      else if (!tgt_valid)     cause[C_MV_NOTGT]  = 1'b1;
      else if (!tgt_ready)     cause[C_MV_NOTRDY] = 1'b1;
      else                     move_fire = 1'b1;
    end
    if (trig_fire) begin
      if (trig_inval)               nxt = ST_NOT_SET;
      else if (state == ST_NOT_SET) nxt = ST_RUNNING;
      else                          cause[C_SEND_STATE] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_ERROR;
    else        state <= nxt;
  end
endmodule

// File: rtl/tod_target.sv
module tod_target
  import tod_pkg::*;
#(
  parameter int          NUM_CORES      = 8,
  parameter int          CORE_FIELD_LSB = 12,
  parameter logic [19:0] UNIT_BASE      = 20'h20000,
  parameter logic [11:0] UNIT_REG       = 12'h4A3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         do_target,
  input  logic [31:0]                  hi_word,
  input  logic                         addr_mode,
  input  logic                         move_fire,
  input  logic [NUM_CORES-1:0]         core_ready,
  output logic                         tgt_valid,
  output logic                         tgt_ready,
  output logic                         xfer_pulse,
  output logic [$clog2(NUM_CORES)-1:0] xfer_core,
  output logic [NCAUSE-1:0]            cause
);
  localparam int          CW         = $clog2(NUM_CORES);
  localparam logic [19:0] FIELD_MASK = 20'h1F << CORE_FIELD_LSB;

  logic [4:0]  id5;
  logic        full_ok;
  logic        dec_ok;
  logic [19:0] upper;

  assign upper   = hi_word[31:12];
  assign full_ok = (hi_word[11:0] == UNIT_REG) &&
                   ((upper & ~FIELD_MASK) == UNIT_BASE);
  assign id5     = addr_mode ? upper[CORE_FIELD_LSB +: 5] : hi_word[4:0];
  assign dec_ok  = (!addr_mode || full_ok) && (32'(id5) < NUM_CORES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_valid  <= 1'b0;
      xfer_core  <= '0;
      xfer_pulse <= 1'b0;
    end else begin
      xfer_pulse <= move_fire;
      if (do_target) begin
        tgt_valid <= dec_ok;
        xfer_core <= id5[CW-1:0];
      end
    end
  end

  assign tgt_ready = core_ready[xfer_core];

  always_comb begin
    cause            = '0;
    cause[C_TGT_BAD] = do_target && !dec_ok;
  end
endmodule

// File: rtl/tod_sync_ctrl.sv
module tod_sync_ctrl
  import tod_pkg::*;
#(
  parameter int          AW             = 6,
  parameter int          NUM_CORES      = 8,
  parameter int          CORE_FIELD_LSB = 12,
  parameter logic [19:0] UNIT_BASE      = 20'h20000,
  parameter logic [11:0] UNIT_REG       = 12'h4A3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         is_primary,
  input  logic                         is_secondary,
  input  logic                         acc_valid,
  input  logic                         acc_write,
  input  logic [AW-1:0]                acc_addr,
  input  logic [63:0]                  acc_wdata,
  output logic                         rsp_valid,
  output logic [63:0]                  rsp_data,
  input  logic                         trig_in_valid,
  output logic                         trig_in_ready,
  input  logic                         trig_in_type,
  output logic                         trig_out_valid,
  input  logic                         trig_out_ready,
  output logic                         trig_out_type,
  input  logic [NUM_CORES-1:0]         core_ready,
  output logic                         xfer_pulse,
  output logic [$clog2(NUM_CORES)-1:0] xfer_core,
  output logic                         illegal_cmd,
  output logic [2:0]                   fsm_state
);
  cmd_t              cmd;
  logic              rd_en;
  tod_state_e        state;
  logic              move_fire;
  logic              tgt_valid;
  logic              tgt_ready;
  logic              trig_fire;
  logic [NCAUSE-1:0] fsm_cause;
  logic [NCAUSE-1:0] tgt_cause;
  logic [NCAUSE-1:0] bc_cause;
  logic [NCAUSE-1:0] all_cause;
  logic [63:0]       err_set;
  logic [63:0]       err_q;
  logic [31:0]       ctrl_q;
  logic              bc_busy;
  logic [63:0]       rd_mux;
  logic [63:0]       status_w;

  tod_cmd_dec #(.AW(AW)) u_dec (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .cmd       (cmd),
    .rd_en     (rd_en)
  );

  // peers are held off while a register write is in flight
  assign trig_in_ready = !(acc_valid && acc_write);
  assign trig_fire     = trig_in_valid && trig_in_ready;

  tod_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .do_ldmod   (cmd.ldmod),
    .do_load    (cmd.load),
    .do_start   (cmd.start),
    .do_move    (cmd.move),
    .bit0       (acc_wdata[be(0)]),
    .bit63      (acc_wdata[be(63)]),
    .trig_fire  (trig_fire),
    .trig_inval (trig_in_type),
    .tgt_valid  (tgt_valid),
    .tgt_ready  (tgt_ready),
    .state      (state),
    .move_fire  (move_fire),
    .cause      (fsm_cause)
  );

  tod_target #(
    .NUM_CORES      (NUM_CORES),
    .CORE_FIELD_LSB (CORE_FIELD_LSB),
    .UNIT_BASE      (UNIT_BASE),
    .UNIT_REG       (UNIT_REG)
  ) u_tgt (
    .clk        (clk),
    .rst_n      (rst_n),
    .do_target  (cmd.target),
    .hi_word    (acc_wdata[63:32]),
    .addr_mode  (acc_wdata[be(35)]),
    .move_fire  (move_fire),
    .core_ready (core_ready),
    .tgt_valid  (tgt_valid),
    .tgt_ready  (tgt_ready),
    .xfer_pulse (xfer_pulse),
    .xfer_core  (xfer_core),
    .cause      (tgt_cause)
  );

  // outbound trigger holding register
  assign bc_busy = trig_out_valid && !trig_out_ready;
  always_comb begin
    bc_cause            = '0;
    bc_cause[C_BC_BUSY] = (cmd.send || cmd.inval) && bc_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_out_valid <= 1'b0;
      trig_out_type  <= 1'b0;
    end else if ((cmd.send || cmd.inval) && !bc_busy) begin
      trig_out_valid <= 1'b1;
      trig_out_type  <= cmd.inval;
    end else if (trig_out_ready) begin
      trig_out_valid <= 1'b0;
    end
  end

  // error register: cause c lands on big-endian bit c
  assign all_cause = fsm_cause | tgt_cause | bc_cause;
  always_comb begin
    err_set = '0;
    for (int c = 0; c < NCAUSE; c++) err_set[be(c)] = all_cause[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (err_q & ~(cmd.err ? acc_wdata : 64'd0)) | err_set;
  end
  assign illegal_cmd = |err_q;

  // control register: big-endian bits 0..31 are stored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      ctrl_q[30] <= is_primary;
      ctrl_q[29] <= 1'b1;
    end else if (cmd.ctrl) begin
      ctrl_q     <= acc_wdata[63:32];
      ctrl_q[30] <= is_primary;
      ctrl_q[29] <= 1'b1;
    end
  end

  always_comb begin
    status_w = '0;
    for (int b = 6; b <= 10; b++) status_w[be(b)] = 1'b1;
    status_w[be(12)] = 1'b1;
    status_w[be(21)] = 1'b1;
    status_w[be(26)] = 1'b1;
    status_w[be(20)] = (state == ST_RUNNING);
    if (is_primary)        status_w[be(23)] = 1'b1;
    else if (is_secondary) status_w[be(24)] = 1'b1;
    else                   status_w[be(25)] = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    if (acc_addr == AW'(OFF_CTRL))        rd_mux = {ctrl_q, 32'd0};
    else if (acc_addr == AW'(OFF_STATUS)) rd_mux = status_w;
    else if (acc_addr == AW'(OFF_ERR))    rd_mux = err_q;
    else if (acc_addr == AW'(OFF_FSM))    rd_mux[be(4)] = (state == ST_RUNNING);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= rd_mux;
    end
  end

  assign fsm_state = state;
endmodule

// File: rtl/tod_sync_ctrl_chk.sv
module tod_sync_ctrl_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_write,
  input logic [AW-1:0] acc_addr,
  input logic          trig_in_valid,
  input logic          trig_in_ready,
  input logic          trig_in_type,
  input logic          trig_out_valid,
  input logic          trig_out_ready,
  input logic          trig_out_type,
  input logic          xfer_pulse,
  input logic          illegal_cmd,
  input logic          rsp_valid,
  input logic [2:0]    fsm_state
);
  // R1
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == 3'd0) || (fsm_state == 3'd1) || (fsm_state == 3'd2) || (fsm_state == 3'd7));

  // R11
  xfer_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_pulse |-> ($past(fsm_state) == 3'd2) && $past(acc_valid && acc_write && acc_addr == AW'(8'h17)));

  // R11
  xfer_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_pulse |=> !xfer_pulse);

  // R5
  inval_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in_valid && trig_in_ready && trig_in_type) |=> (fsm_state == 3'd7));

  // R5
  in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |-> !trig_in_ready);

  // R4
  start_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr == AW'(8'h22) && fsm_state == 3'd1) |=> (fsm_state == 3'd2));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_cmd && !(acc_valid && acc_write && acc_addr == AW'(8'h30))) |=> illegal_cmd);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out_valid && !trig_out_ready) |=> trig_out_valid && $stable(trig_out_type));

  // R12
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc_valid && !acc_write));
endmodule

bind tod_sync_ctrl tod_sync_ctrl_chk #(.AW(AW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .acc_valid      (acc_valid),
  .acc_write      (acc_write),
  .acc_addr       (acc_addr),
  .trig_in_valid  (trig_in_valid),
  .trig_in_ready  (trig_in_ready),
  .trig_in_type   (trig_in_type),
  .trig_out_valid (trig_out_valid),
  .trig_out_ready (trig_out_ready),
  .trig_out_type  (trig_out_type),
  .xfer_pulse     (xfer_pulse),
  .illegal_cmd    (illegal_cmd),
  .rsp_valid      (rsp_valid),
  .fsm_state      (fsm_state)
);

// File: tb/tb_tod_sync_ctrl.sv
module tb_tod_sync_ctrl;
  localparam int AW = 6;
  localparam int NC = 8;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] GO   = 64'h8000_0000_0000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          is_primary = 1'b1;
  logic          is_secondary = 1'b0;
  logic          acc_valid = 1'b0;
  logic          acc_write = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [63:0]   acc_wdata = '0;
  logic          rsp_valid;
  logic [63:0]   rsp_data;
  logic          trig_in_valid = 1'b0;
  logic          trig_in_ready;
  logic          trig_in_type = 1'b0;
  logic          trig_out_valid;
  logic          trig_out_ready = 1'b1;
  logic          trig_out_type;
  logic [NC-1:0] core_ready = '1;
  logic          xfer_pulse;
  logic [2:0]    xfer_core;
  logic          illegal_cmd;
  logic [2:0]    fsm_state;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  tod_sync_ctrl #(.AW(AW), .NUM_CORES(NC)) dut (
    .clk(clk), .rst_n(rst_n), .is_primary(is_primary), .is_secondary(is_secondary),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .trig_in_valid(trig_in_valid), .trig_in_ready(trig_in_ready), .trig_in_type(trig_in_type),
    .trig_out_valid(trig_out_valid), .trig_out_ready(trig_out_ready), .trig_out_type(trig_out_type),
    .core_ready(core_ready), .xfer_pulse(xfer_pulse), .xfer_core(xfer_core),
    .illegal_cmd(illegal_cmd), .fsm_state(fsm_state)
  );

  // {op(0=write,1=trigger), offset, data, expected state, expected flag}
  localparam int NV = 18;
  localparam logic [75:0] VEC [NV] = '{
    {2'd0, 6'h21, 64'h0, 3'd0, 1'b1},
    {2'd0, 6'h30, ONES,  3'd0, 1'b0},
    {2'd0, 6'h18, 64'h0, 3'd0, 1'b1},
    {2'd0, 6'h30, ONES,  3'd0, 1'b0},
    {2'd0, 6'h18, GO,    3'd7, 1'b0},
    {2'd0, 6'h22, 64'h0, 3'd7, 1'b1},
    {2'd0, 6'h30, ONES,  3'd7, 1'b0},
    {2'd0, 6'h21, 64'h1, 3'd1, 1'b0},
    {2'd0, 6'h22, 64'h0, 3'd2, 1'b0},
    {2'd1, 6'h00, 64'h1, 3'd7, 1'b0},
    {2'd1, 6'h00, 64'h0, 3'd2, 1'b0},
    {2'd1, 6'h00, 64'h0, 3'd2, 1'b1},
    {2'd0, 6'h30, ONES,  3'd2, 1'b0},
    {2'd0, 6'h18, GO,    3'd7, 1'b0},
    {2'd0, 6'h21, 64'h0, 3'd2, 1'b0},
    {2'd0, 6'h21, 64'h0, 3'd2, 1'b1},
    {2'd0, 6'h30, ONES,  3'd2, 1'b0},
    {2'd1, 6'h00, 64'h1, 3'd7, 1'b0}
  };

  function automatic logic [63:0] bb(input int b);
    return 64'd1 << (63 - b);
  endfunction

  function automatic logic [63:0] stat_exp(input logic run, input logic pri, input logic sec);
    logic [63:0] v;
    v = bb(6) | bb(7) | bb(8) | bb(9) | bb(10) | bb(12) | bb(21) | bb(26);
    if (run) v = v | bb(20);
    if (pri) v = v | bb(23);
    else if (sec) v = v | bb(24);
    else v = v | bb(25);
    return v;
  endfunction

  function automatic string req_of(input logic [1:0] op, input logic [5:0] a);
    if (op == 2'd1) return "R5";
    case (a)
      6'h21: return "R3";
      6'h18: return "R2";
      6'h22: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [63:0] d, output logic v);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
    @(negedge clk);
    d = rsp_data; v = rsp_valid;
    acc_valid = 1'b0;
  endtask

  task automatic trig(input logic t);
    trig_in_valid = 1'b1; trig_in_type = t;
    @(negedge clk);
    trig_in_valid = 1'b0;
  endtask

  task automatic rdchk(input logic [5:0] a, input logic [63:0] e, input string req);
    logic [63:0] d;
    logic v;
    rd(a, d, v);
    chk(v && d == e, req, d, e);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(fsm_state == 3'd0, "R1", 64'(fsm_state), 64'd0);
    chk(!illegal_cmd && !trig_out_valid && !xfer_pulse, "R1",
        {61'd0, illegal_cmd, trig_out_valid, xfer_pulse}, 64'd0);
    rdchk(6'h30, 64'd0, "R1");
    rdchk(6'h07, 64'h6000_0000_0000_0000, "R8");
    rdchk(6'h08, stat_exp(1'b0, 1'b1, 1'b0), "R7");
    rdchk(6'h24, 64'd0, "R9");
    // R12 undecoded offset and response timing
    rd(6'h3F, d, v);
    chk(v && d == 64'd0, "R12", d, 64'd0);
    @(negedge clk);
    chk(!rsp_valid, "R12", 64'(rsp_valid), 64'd0);

    // state table walk
    for (int i = 0; i < NV; i++) begin
      logic [75:0] e;
      e = VEC[i];
      if (e[75:74] == 2'd1) trig(e[4]);
      else                  wr(e[73:68], e[67:4]);
      chk(fsm_state == e[3:1] && illegal_cmd == e[0], req_of(e[75:74], e[73:68]),
          {60'd0, fsm_state, illegal_cmd}, {60'd0, e[3:0]});
    end

    // R3 error cause bit for load outside not set
    wr(6'h22, 64'd0);
    rdchk(6'h30, bb(2), "R4");
    wr(6'h30, ONES);
    wr(6'h21, 64'h1);
    chk(fsm_state == 3'd1, "R3", 64'(fsm_state), 64'd1);
    wr(6'h21, 64'h0);
    wr(6'h18, 64'h0);
    // R9 partial clear keeps the other bit
    rdchk(6'h30, bb(0) | bb(1), "R9");
    wr(6'h30, bb(1));
    rdchk(6'h30, bb(0), "R9");
    chk(illegal_cmd, "R9", 64'(illegal_cmd), 64'd1);
    wr(6'h30, ONES);
    chk(!illegal_cmd, "R9", 64'(illegal_cmd), 64'd0);
    wr(6'h22, 64'd0);
    chk(fsm_state == 3'd2, "R4", 64'(fsm_state), 64'd2);
    rdchk(6'h24, bb(4), "R9");
    rdchk(6'h08, stat_exp(1'b1, 1'b1, 1'b0), "R7");

    // R8 control forcing, both strap values
    wr(6'h07, ONES);
    rdchk(6'h07, 64'hFFFF_FFFF_0000_0000, "R8");
    is_primary = 1'b0; is_secondary = 1'b1;
    wr(6'h07, ONES);
    rdchk(6'h07, 64'hBFFF_FFFF_0000_0000, "R8");
    wr(6'h07, 64'd0);
    rdchk(6'h07, 64'h2000_0000_0000_0000, "R8");
    rdchk(6'h08, stat_exp(1'b1, 1'b0, 1'b1), "R7");
    is_secondary = 1'b0;
    rdchk(6'h08, stat_exp(1'b1, 1'b0, 1'b0), "R7");
    is_primary = 1'b1;

    // R11 no target latched yet
    wr(6'h17, GO);
    chk(!xfer_pulse, "R11", 64'(xfer_pulse), 64'd0);
    rdchk(6'h30, bb(6), "R11");
    wr(6'h30, ONES);

    // R10 core-id mode, 6-bit field 0x25 masked to core 5
    wr(6'h27, {32'h0000_0025, 32'h0});
    chk(!illegal_cmd, "R10", 64'(illegal_cmd), 64'd0);
    core_ready = 8'b1101_1111;
    wr(6'h17, GO);
    chk(!xfer_pulse, "R11", 64'(xfer_pulse), 64'd0);
    rdchk(6'h30, bb(7), "R11");
    wr(6'h30, ONES);
    core_ready = '1;
    wr(6'h17, GO);
    chk(xfer_pulse && xfer_core == 3'd5, "R10", {60'd0, xfer_pulse, xfer_core}, {60'd0, 1'b1, 3'd5});
    @(negedge clk);
    chk(!xfer_pulse, "R11", 64'(xfer_pulse), 64'd0);
    wr(6'h17, 64'd0);
    chk(!xfer_pulse, "R11", 64'(xfer_pulse), 64'd0);
    rdchk(6'h30, bb(5), "R11");
    wr(6'h30, ONES);

    // R10 full-address mode, core 3
    wr(6'h27, {32'h2300_04A3, 32'h1000_0000});
    wr(6'h17, GO);
    chk(xfer_pulse && xfer_core == 3'd3, "R10", {60'd0, xfer_pulse, xfer_core}, {60'd0, 1'b1, 3'd3});
    @(negedge clk);
    // R10 wrong unit register invalidates target
    wr(6'h27, {32'h2300_04A4, 32'h1000_0000});
    rdchk(6'h30, bb(8), "R10");
    wr(6'h30, ONES);
    wr(6'h17, GO);
    chk(!xfer_pulse, "R10", 64'(xfer_pulse), 64'd0);
    wr(6'h30, ONES);
    // R10 core number beyond range
    wr(6'h27, {32'h0000_0009, 32'h0});
    chk(illegal_cmd, "R10", 64'(illegal_cmd), 64'd1);
    wr(6'h30, ONES);

    // R5 back-pressure: trigger held off during a write
    wr(6'h27, {32'h0000_0002, 32'h0});
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 6'h07; acc_wdata = 64'd0;
    trig_in_valid = 1'b1; trig_in_type = 1'b1;
    #1;
    chk(!trig_in_ready, "R5", 64'(trig_in_ready), 64'd0);
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    chk(fsm_state == 3'd2, "R5", 64'(fsm_state), 64'd2);
    @(negedge clk);
    trig_in_valid = 1'b0;
    chk(fsm_state == 3'd7, "R5", 64'(fsm_state), 64'd7);
    // R11 transfer refused outside running
    wr(6'h17, GO);
    chk(!xfer_pulse, "R11", 64'(xfer_pulse), 64'd0);
    rdchk(6'h30, bb(4), "R11");
    wr(6'h30, ONES);

    // R6 outbound trigger held, second rejected, own state untouched
    trig_out_ready = 1'b0;
    wr(6'h15, 64'd0);
    chk(trig_out_valid && !trig_out_type, "R6", {62'd0, trig_out_valid, trig_out_type}, 64'd2);
    chk(fsm_state == 3'd7, "R6", 64'(fsm_state), 64'd7);
    wr(6'h16, 64'd0);
    chk(trig_out_valid && !trig_out_type && illegal_cmd, "R6",
        {61'd0, trig_out_valid, trig_out_type, illegal_cmd}, 64'd5);
    rdchk(6'h30, bb(9), "R6");
    trig_out_ready = 1'b1;
    @(negedge clk);
    chk(!trig_out_valid, "R6", 64'(trig_out_valid), 64'd0);
    wr(6'h16, 64'd0);
    chk(trig_out_valid && trig_out_type && fsm_state == 3'd7, "R6",
        {60'd0, trig_out_valid, trig_out_type, fsm_state[1:0]}, 64'hF);
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    done = 1'b1;
    $finish;
  end
endmodule